// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register of the most recent resolved outcomes across all branches. It also keeps a table of two-bit saturating confidence counters. The low bits of the branch address are XORed with that shared history to pick one counter. The upper bit of the chosen counter is the guess.

A fetch stage presents a branch address on the lookup port. The guess comes back in the same cycle, with no register on that path. When the branch resolves later, the execute stage presents the same address and the real outcome on the update port. That strengthens or weakens the chosen counter and pushes the outcome into the history. A lookup and an update may occur in the same cycle. The lookup then sees the state from before that update.

Top module: `gshare_dir_predictor`

## Requirements
- R1: A synchronous active-high reset clears the history to all zeros and sets every counter to 2 (weakly taken), in one cycle. After reset, every lookup address predicts taken.
- R2: The guess is taken (1) when the selected counter holds 2 or 3, and not taken (0) when it holds 0 or 1.
- R3: The selected entry is the low index-width bits of the address XORed with the history. Lookup and update use the same rule.
- R4: A valid update with outcome taken raises the selected counter by one. The counter stays at 3 once it has reached 3.
- R5: A valid update with outcome not taken lowers the selected counter by one. The counter stays at 0 once it has reached 0.
- R6: A valid update shifts the history left by one place. The new outcome enters bit 0 and the oldest bit is dropped.
- R7: The counter chosen by an update is indexed with the history held before that same update's shift.
- R8: The guess is combinational from the lookup address and the registered state. In a cycle that also carries an update, the guess reflects the state before that update.
- R9: While the update-valid input is low, neither the counters nor the history change, whatever the update address and outcome are.
- R10: Address bits above the index width have no effect on the guess or on which counter an update touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lookup_pc | input | PC_W (32) | Address of the branch being predicted |
| lookup_taken | output | 1 | Guess for lookup_pc: 1 taken, 0 not taken |
| upd_valid | input | 1 | Qualifies an update in this cycle |
| upd_pc | input | PC_W (32) | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch: 1 taken |

## Verification
The bench uses the default parameters: a 32-bit address, and an 8-bit index and history, so the table holds 256 counters. A table this small allows a full sweep of all 256 entries after each scenario, compared against an independent model of the table. Any stray write, wrong history bit or wrong index rule therefore shows up somewhere in the sweep. With a 32-bit address, the bench can also set the upper address bits to arbitrary patterns, which confirms that only the low eight bits select an entry.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int DEF_PC_W  = 32;
    localparam int DEF_IDX_W = 8;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    // One saturating step of a confidence counter toward the observed outcome.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bp_index_hash.sv
module bp_index_hash #(
    parameter int PC_W  = bp_pkg::DEF_PC_W,
    parameter int IDX_W = bp_pkg::DEF_IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);
    // Only the low address bits fold into the index; upper bits are unused.
    logic [IDX_W-1:0] pc_low;

    always_comb begin
        pc_low = pc[IDX_W-1:0];
        idx    = pc_low ^ hist;
    end

    logic unused_upper;
    assign unused_upper = ^pc[PC_W-1:IDX_W];

endmodule

// File: rtl/bp_history.sv
module bp_history #(
    parameter int HIST_W = bp_pkg::DEF_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else if (shift_en) begin
            st_d.bits = {st_q.bits[HIST_W-2:0], outcome};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hist = st_q.bits;

    // R1: history is empty right after reset
    assert_hist_clear_R1: assert property (@(posedge clk)
        rst |=> (hist == '0));

    // R6: newest outcome lands in bit 0
    assert_hist_newest_R6: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (hist[0] == $past(outcome)));

    // R9: no shift without a valid update
    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist));

endmodule

// File: rtl/bp_pattern_table.sv
module bp_pattern_table #(
    parameter int IDX_W = bp_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    import bp_pkg::*;

    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } tbl_state_t;

    tbl_state_t st_d, st_q;
    logic [1:0] wr_old;

    always_comb begin
        wr_old = st_q.ctr[wr_idx];
        st_d   = st_q;
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.ctr[i] = CTR_WEAK_T;
            end
        end else if (wr_en) begin
            st_d.ctr[wr_idx] = ctr_step(wr_old, wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_ctr = st_q.ctr[rd_idx];

    // R4: a strongly-taken counter stays put on another taken outcome
    assert_sat_high_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && wr_old == CTR_STRONG_T) |=> (st_q.ctr[$past(wr_idx)] == CTR_STRONG_T));

    // R4: below the ceiling a taken outcome advances by exactly one
    assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && wr_old != CTR_STRONG_T) |=> (st_q.ctr[$past(wr_idx)] == $past(wr_old) + 2'd1));

    // R5: a strongly-not-taken counter stays put on another not-taken outcome
    assert_sat_low_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && wr_old == CTR_STRONG_NT) |=> (st_q.ctr[$past(wr_idx)] == CTR_STRONG_NT));

    // R5: above the floor a not-taken outcome retreats by exactly one
    assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && wr_old != CTR_STRONG_NT) |=> (st_q.ctr[$past(wr_idx)] == $past(wr_old) - 2'd1));

    // R9: read entry unchanged when nothing is written
    assert_tbl_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (st_q.ctr[$past(rd_idx)] == $past(rd_ctr)));

endmodule

// File: rtl/gshare_dir_predictor.sv
module gshare_dir_predictor #(
    parameter int PC_W  = bp_pkg::DEF_PC_W,
    parameter int IDX_W = bp_pkg::DEF_IDX_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lookup_pc,
    output logic            lookup_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int HIST_W = IDX_W;

    logic [HIST_W-1:0] hist;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [1:0]        rd_ctr;

    bp_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash_rd (
        .pc   (lookup_pc),
        .hist (hist),
        .idx  (rd_idx)
    );

    // R7: update index is formed from the pre-shift history
    bp_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash_wr (
        .pc   (upd_pc),
        .hist (hist),
        .idx  (wr_idx)
    );

    bp_pattern_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken)
    );

    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid),
        .outcome  (upd_taken),
        .hist     (hist)
    );

    // R2: upper counter bit carries the direction
    assign lookup_taken = rd_ctr[1];

    // R1: every lookup predicts taken in the cycle after reset
    assert_reset_weak_R1: assert property (@(posedge clk)
        rst |=> lookup_taken);

endmodule

// File: tb/gshare_dir_predictor_bench.sv
module gshare_dir_predictor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 32;
    localparam int IDX_W      = 8;
    localparam int ENTRIES    = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] lookup_pc = '0;
    logic            lookup_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    int mdl [ENTRIES];
    logic [IDX_W-1:0] mhist;

    always #(CLK_PERIOD/2) clk = ~clk;

    gshare_dir_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_gshare_dir_predictor (
        .clk          (clk),
        .rst          (rst),
        .lookup_pc    (lookup_pc),
        .lookup_taken (lookup_taken),
        .upd_valid    (upd_valid),
        .upd_pc       (upd_pc),
        .upd_taken    (upd_taken)
    );

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic mdl_pred(input logic [PC_W-1:0] pc);
        logic [IDX_W-1:0] i;
        i = pc[IDX_W-1:0] ^ mhist;
        return mdl[i] >= 2;
    endfunction

    // Apply one lookup between edges and compare with the model.
    task automatic probe(input string req, input logic [PC_W-1:0] pc);
        @(negedge clk);
        lookup_pc = pc;
        #1;
        check_bit(req, lookup_taken, mdl_pred(pc));
    endtask

    // Probe one table entry through the current history.
    task automatic probe_entry(input string req, input int ent, input logic [PC_W-IDX_W-1:0] upper);
        logic [IDX_W-1:0] low;
        low = IDX_W'(ent) ^ mhist;
        probe(req, {upper, low});
    endtask

    task automatic sweep(input string req, input logic [PC_W-IDX_W-1:0] upper);
        for (int e = 0; e < ENTRIES; e++) probe_entry(req, e, upper);
    endtask

    task automatic do_update(input logic [PC_W-1:0] pc, input logic tk);
        logic [IDX_W-1:0] i;
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = tk;
        @(posedge clk);
        i = pc[IDX_W-1:0] ^ mhist;
        if (tk) begin
            if (mdl[i] < 3) mdl[i]++;
        end else begin
            if (mdl[i] > 0) mdl[i]--;
        end
        mhist = {mhist[IDX_W-2:0], tk};
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // Update aimed at a fixed entry regardless of the current history.
    task automatic hit_entry(input int ent, input logic tk, input logic [PC_W-IDX_W-1:0] upper);
        logic [IDX_W-1:0] low;
        low = IDX_W'(ent) ^ mhist;
        do_update({upper, low}, tk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mhist = '0;
        for (int e = 0; e < ENTRIES; e++) mdl[e] = 2;
        // R1: every entry weakly taken, history zero
        sweep("R1", 24'h000000);
        probe("R1", 32'hDEAD_BE5A);
    endtask

    task automatic t_saturate_up;
        // R4: four taken hits reach 3; two not-taken then bring it to 1
        for (int k = 0; k < 4; k++) hit_entry(8'h35, 1'b1, 24'h000100);
        probe_entry("R4", 8'h35, 24'h0);
        hit_entry(8'h35, 1'b0, 24'h0);
        probe_entry("R4", 8'h35, 24'h0);
        check_bit("R4", lookup_taken, 1'b1);
        hit_entry(8'h35, 1'b0, 24'h0);
        probe_entry("R4", 8'h35, 24'h0);
        check_bit("R4", lookup_taken, 1'b0);
    endtask

    task automatic t_saturate_down;
        // R5: four not-taken hits reach 0; two taken then bring it to 2
        for (int k = 0; k < 4; k++) hit_entry(8'hC2, 1'b0, 24'h000000);
        probe_entry("R5", 8'hC2, 24'h0);
        check_bit("R5", lookup_taken, 1'b0);
        hit_entry(8'hC2, 1'b1, 24'h0);
        probe_entry("R5", 8'hC2, 24'h0);
        check_bit("R5", lookup_taken, 1'b0);
        hit_entry(8'hC2, 1'b1, 24'h0);
        probe_entry("R5", 8'hC2, 24'h0);
        check_bit("R5", lookup_taken, 1'b1);
        sweep("R5", 24'h0);
    endtask

    task automatic t_history_index;
        // R6 R7 R3: alternating outcomes on one fixed address walk the index
        for (int k = 0; k < 12; k++) do_update(32'h0000_0077, k[0]);
        sweep("R6", 24'h0);
        for (int k = 0; k < 9; k++) do_update(32'h0000_0011, 1'b0);
        sweep("R7", 24'h0);
        for (int k = 0; k < 8; k++) do_update(32'h0000_00A0 + k, (k % 3) == 0);
        sweep("R3", 24'h0);
    endtask

    task automatic t_same_cycle;
        logic [IDX_W-1:0] low;
        logic             old_pred;
        // R8: drive a not-taken update to the looked-up entry in the same cycle
        hit_entry(8'h5B, 1'b1, 24'h0);
        low = 8'h5B ^ mhist;
        @(negedge clk);
        lookup_pc = {24'h0, low};
        upd_valid = 1'b1;
        upd_pc    = {24'h0, low};
        upd_taken = 1'b0;
        #1;
        old_pred = mdl[8'h5B] >= 2;
        check_bit("R8", lookup_taken, old_pred);
        @(posedge clk);
        if (mdl[8'h5B] > 0) mdl[8'h5B]--;
        mhist = {mhist[IDX_W-2:0], 1'b0};
        @(negedge clk);
        upd_valid = 1'b0;
        sweep("R8", 24'h0);
    endtask

    task automatic t_no_valid;
        // R9: toggle update address and outcome with valid low
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            upd_valid = 1'b0;
            upd_pc    = 32'h1357_0000 + (k * 37);
            upd_taken = k[0];
        end
        sweep("R9", 24'h0);
    endtask

    task automatic t_upper_bits;
        // R10: same low bits, other upper bits, on both ports
        for (int k = 0; k < 6; k++) hit_entry(8'h90, 1'b0, 24'hABCDEF ^ 24'(k * 4099));
        sweep("R10", 24'hF0F0F0);
        sweep("R10", 24'h0F0F0F);
        probe_entry("R10", 8'h90, 24'hFFFFFF);
        check_bit("R10", lookup_taken, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_saturate_up();
        t_saturate_down();
        t_history_index();
        t_same_cycle();
        t_no_valid();
        t_upper_bits();
        t_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule